// File: doc/BRIEF.md
# Eight-Pin Configurable I/O Port with Change Interrupt

This block is one general purpose I/O port with eight pins. Each pin has its own direction, output value, inversion, sensing mode and interrupt enable. A single register write interface loads the configuration. Each write carries a 4-bit select code and an 8-bit data word. Some select codes replace a whole register. Others act only on the pins whose data bit is one (set, clear and toggle), so one write can reconfigure several pins without touching the rest.

An inversion bit per pin sits between the pin's registers and its pad, in both directions. On the output side it also covers a pin that an alternate function drives. On the input side the pad value can be taken directly, which is asynchronous, or through a two-flop synchronizer. The resulting input value feeds an event detector. Each pin can select both edges, rising edge, falling edge or low level. A detected event sets a sticky per-pin flag, which is cleared by writing one to it. A single interrupt request is the OR of the flags allowed through a per-pin mask.

Top module: `gpio_port`

## Requirements
- R1: After reset, every configuration register and every flag is zero, so `pad_oe`, `pad_out`, `out_state`, `flags` and `irq` are all zero.
- R2: Select 0 loads the whole direction register and select 4 loads the whole output register. `pad_oe` follows the direction register, and no other select changes it.
- R3: Selects 1, 2 and 3 set, clear and toggle direction bits, and selects 5, 6 and 7 do the same for output bits. Only bits whose data bit is one change.
- R4: Select 8 loads the inversion register. A pin that is not overridden drives `pad_out[i] = out_state[i] ^ inv[i]`.
- R5: When `alt_en[i]` is one, `pad_out[i] = alt_out[i] ^ inv[i]`, whatever the value of the output register.
- R6: The input value reported on `in_state[i]` is the sensed pad value XOR `inv[i]`.
- R7: Select 9 loads the synchronous-mode register. A pin with the bit at 1 shows a pad change on `in_state` after the second rising clock edge. A pin with the bit at 0 shows it in the same cycle, without a register.
- R8: Select 12 loads the low bit and select 13 the high bit of each pin's 2-bit sense code: 00 both edges, 01 rising, 10 falling, 11 low level. Events are taken on `in_state`, and the flag sets on the first clock edge at which the event is seen.
- R9: Select 11 clears the flags whose data bit is one and leaves the others alone. An event on the same edge wins over the clear.
- R10: Select 10 loads the interrupt mask. `irq` is high exactly when some flag with its mask bit set is high, in the same cycle.
- R11: Selects 14 and 15 have no effect on any register or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select code |
| wr_data | input | 8 | Write data, one bit per pin |
| pad_in | input | 8 | Pad input levels |
| alt_en | input | 8 | Per-pin alternate-function override enable |
| alt_out | input | 8 | Alternate-function output values |
| pad_out | output | 8 | Pad output levels after inversion |
| pad_oe | output | 8 | Pad output enables (direction) |
| out_state | output | 8 | Output register contents |
| in_state | output | 8 | Sensed input values after inversion |
| flags | output | 8 | Sticky per-pin event flags |
| irq | output | 1 | Port interrupt request |

## Verification
A register write presented in one cycle shows on `out_state`, `pad_oe` and `pad_out` after the next rising edge. The bench drives each write on a falling edge and samples at the following falling edge. Override and asynchronous input changes reach `pad_out` and `in_state` with no clock edge, so they are sampled a short delay after the drive. A synchronous pin is sampled once after one edge, where it must still hold the old value, and again after the second edge, where it must show the new value. Flags are sampled one edge after the event is visible on `in_state`. `irq` is sampled in the same cycle as the flag and mask it depends on.

// File: rtl/gpio_port_pkg.sv
// Package gpio_port_pkg
// Shared select codes and sense-mode encoding for the I/O port.
// Assumes a 4-bit select field. The low two bits of the direction and
// output selects pick the write operation (load, set, clear, toggle).
package gpio_port_pkg;

    localparam int SEL_W = 4;

    localparam logic [SEL_W-1:0] SEL_DIR      = 4'd0;
    localparam logic [SEL_W-1:0] SEL_DIR_SET  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_DIR_CLR  = 4'd2;
    localparam logic [SEL_W-1:0] SEL_DIR_TGL  = 4'd3;
    localparam logic [SEL_W-1:0] SEL_OUT      = 4'd4;
    localparam logic [SEL_W-1:0] SEL_OUT_SET  = 4'd5;
    localparam logic [SEL_W-1:0] SEL_OUT_CLR  = 4'd6;
    localparam logic [SEL_W-1:0] SEL_OUT_TGL  = 4'd7;
    localparam logic [SEL_W-1:0] SEL_INV      = 4'd8;
    localparam logic [SEL_W-1:0] SEL_SYNC     = 4'd9;
    localparam logic [SEL_W-1:0] SEL_MASK     = 4'd10;
    localparam logic [SEL_W-1:0] SEL_FLAG_CLR = 4'd11;
    localparam logic [SEL_W-1:0] SEL_SENSE_LO = 4'd12;
    localparam logic [SEL_W-1:0] SEL_SENSE_HI = 4'd13;

    // Write operation carried in the low two bits of a direction/output select
    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } wr_op_e;

    // Per-pin event selection
    typedef enum logic [1:0] {
        SENSE_BOTH = 2'd0,
        SENSE_RISE = 2'd1,
        SENSE_FALL = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_e;

endpackage

// File: rtl/gpio_cfg_regs.sv
// Module gpio_cfg_regs
// Configuration register file of the port. Direction and output registers
// accept load, set, clear and toggle writes; the others are loaded whole.
// A flag-clear write produces a one-cycle clear vector and stores nothing.
// Assumes one write per cycle. Unlisted select codes are ignored.
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] dir_o,
    output logic [NPINS-1:0] out_o,
    output logic [NPINS-1:0] inv_o,
    output logic [NPINS-1:0] sync_o,
    output logic [NPINS-1:0] mask_o,
    output logic [NPINS-1:0] sense_lo_o,
    output logic [NPINS-1:0] sense_hi_o,
    output logic [NPINS-1:0] flag_clr_o
);

    logic [NPINS-1:0] dir_q, out_q, inv_q, sync_q, mask_q, slo_q, shi_q;

    // Applies a masked write operation to an old register value
    function automatic logic [NPINS-1:0] apply_op(
        input logic [NPINS-1:0] old_v,
        input logic [NPINS-1:0] data_v,
        input wr_op_e           op
    );
        logic [NPINS-1:0] res;
        case (op)
            OP_LOAD:   res = data_v;
            OP_SET:    res = old_v | data_v;
            OP_CLEAR:  res = old_v & ~data_v;
            default:   res = old_v ^ data_v;
        endcase
        return res;
    endfunction

    // Decoded write enables for the direction and output groups
    logic dir_hit, out_hit;
    wr_op_e op_sel;

    // Decode the select into the register group and the operation
    always_comb begin
        dir_hit = wr_en && (wr_sel[SEL_W-1:2] == SEL_DIR[SEL_W-1:2]);
        out_hit = wr_en && (wr_sel[SEL_W-1:2] == SEL_OUT[SEL_W-1:2]);
        op_sel  = wr_op_e'(wr_sel[1:0]);
    end

    // Direction register: load/set/clear/toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (dir_hit) begin
            dir_q <= apply_op(dir_q, wr_data, op_sel);
        end
    end

    // Output register: load/set/clear/toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (out_hit) begin
            out_q <= apply_op(out_q, wr_data, op_sel);
        end
    end

    // Whole-register loads for inversion, sensing, mask and sense codes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q  <= '0;
            sync_q <= '0;
            mask_q <= '0;
            slo_q  <= '0;
            shi_q  <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_INV:      inv_q  <= wr_data;
                SEL_SYNC:     sync_q <= wr_data;
                SEL_MASK:     mask_q <= wr_data;
                SEL_SENSE_LO: slo_q  <= wr_data;
                SEL_SENSE_HI: shi_q  <= wr_data;
                default:      ;
            endcase
        end
    end

    // One-cycle write-one-to-clear vector for the flags
    always_comb begin
        flag_clr_o = (wr_en && wr_sel == SEL_FLAG_CLR) ? wr_data : '0;
    end

    assign dir_o      = dir_q;
    assign out_o      = out_q;
    assign inv_o      = inv_q;
    assign sync_o     = sync_q;
    assign mask_o     = mask_q;
    assign sense_lo_o = slo_q;
    assign sense_hi_o = shi_q;

endmodule

// File: rtl/gpio_pin_cell.sv
// Module gpio_pin_cell
// Datapath of one pin: output select and inversion, input synchronizer,
// input inversion, event detector and sticky flag.
// Assumes the pad input may be asynchronous. In asynchronous mode the caller
// accepts a direct combinational path from pad to in_o.
module gpio_pin_cell
    import gpio_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_i,
    input  logic       inv_i,
    input  logic       sync_i,
    input  logic [1:0] sense_i,
    input  logic       clr_i,
    input  logic       drv_i,
    input  logic       alt_en_i,
    input  logic       alt_i,
    output logic       pad_o,
    output logic       in_o,
    output logic       flag_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   flag_q;
    logic                   sensed;
    logic                   cur;
    logic                   hit;
    sense_e                 mode;

    // Synchronizer chain on the raw pad level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
        end
    end

    // Pick synchronous or direct input, then apply inversion
    always_comb begin
        sensed = sync_i ? sync_q[LAST] : pad_i;
        cur    = sensed ^ inv_i;
    end

    // Previous input value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= cur;
        end
    end

    // Event detector for the selected sense mode
    always_comb begin
        mode = sense_e'(sense_i);
        case (mode)
            SENSE_BOTH: hit = cur ^ prev_q;
            SENSE_RISE: hit = cur & ~prev_q;
            SENSE_FALL: hit = ~cur & prev_q;
            default:    hit = ~cur;
        endcase
    end

    // Sticky flag: an event wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    // Output source select followed by inversion
    always_comb begin
        pad_o = (alt_en_i ? alt_i : drv_i) ^ inv_i;
    end

    assign in_o   = cur;
    assign flag_o = flag_q;

endmodule

// File: rtl/gpio_port.sv
// Module gpio_port
// Top of the eight-pin configurable I/O port. Joins the configuration
// register file to one pin cell per pin and merges the masked flags into
// the interrupt request.
// Assumes synchronous active-low reset and a single write interface.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [NPINS-1:0] wr_data,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] alt_en,
    input  logic [NPINS-1:0] alt_out,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] out_state,
    output logic [NPINS-1:0] in_state,
    output logic [NPINS-1:0] flags,
    output logic             irq
);

    logic [NPINS-1:0] dir_w, out_w, inv_w, sync_w, mask_w;
    logic [NPINS-1:0] slo_w, shi_w, clr_w;
    logic [NPINS-1:0] flag_w;

    gpio_cfg_regs #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .dir_o      (dir_w),
        .out_o      (out_w),
        .inv_o      (inv_w),
        .sync_o     (sync_w),
        .mask_o     (mask_w),
        .sense_lo_o (slo_w),
        .sense_hi_o (shi_w),
        .flag_clr_o (clr_w)
    );

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
        gpio_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .pad_i    (pad_in[gi]),
            .inv_i    (inv_w[gi]),
            .sync_i   (sync_w[gi]),
            .sense_i  ({shi_w[gi], slo_w[gi]}),
            .clr_i    (clr_w[gi]),
            .drv_i    (out_w[gi]),
            .alt_en_i (alt_en[gi]),
            .alt_i    (alt_out[gi]),
            .pad_o    (pad_out[gi]),
            .in_o     (in_state[gi]),
            .flag_o   (flag_w[gi])
        );
    end

    // Interrupt request: any flag allowed by the mask
    always_comb begin
        irq = |(flag_w & mask_w);
    end

    assign pad_oe    = dir_w;
    assign out_state = out_w;
    assign flags     = flag_w;

endmodule

// File: rtl/gpio_port_chk.sv
// Module gpio_port_chk
// Assertion checker for gpio_port, attached by bind. Receives the port
// signals plus the inversion, sync and mask registers.
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [NPINS-1:0] wr_data,
    input logic [NPINS-1:0] pad_in,
    input logic [NPINS-1:0] alt_en,
    input logic [NPINS-1:0] alt_out,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] out_state,
    input logic [NPINS-1:0] in_state,
    input logic [NPINS-1:0] flags,
    input logic             irq,
    input logic [NPINS-1:0] inv_r,
    input logic [NPINS-1:0] sync_r,
    input logic [NPINS-1:0] mask_r
);

    logic [NPINS-1:0] clr_vec;
    logic             dir_wr;

    // Expected clear vector and direction-write indication
    always_comb begin
        clr_vec = (wr_en && wr_sel == SEL_FLAG_CLR) ? wr_data : '0;
        dir_wr  = wr_en && (wr_sel <= SEL_DIR_TGL);
    end

    assert_outset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_OUT_SET) |=> out_state == ($past(out_state) | $past(wr_data)));

    assert_outclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_OUT_CLR) |=> out_state == ($past(out_state) & ~$past(wr_data)));

    assert_outtgl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_OUT_TGL) |=> out_state == ($past(out_state) ^ $past(wr_data)));

    assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_wr |=> $stable(pad_oe));

    assert_pad_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pad_out == (((out_state & ~alt_en) | (alt_out & alt_en)) ^ inv_r));

    assert_async_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_state ^ pad_in ^ inv_r) & ~sync_r) == '0);

    assert_flag_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(flags) & ~flags & ~$past(clr_vec)) == '0);

    assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((flags & mask_r) != '0));

endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .pad_in    (pad_in),
    .alt_en    (alt_en),
    .alt_out   (alt_out),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .out_state (out_state),
    .in_state  (in_state),
    .flags     (flags),
    .irq       (irq),
    .inv_r     (inv_w),
    .sync_r    (sync_w),
    .mask_r    (mask_w)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [3:0] wr_sel;
    logic [7:0] wr_data;
    logic [7:0] pad_in, alt_en, alt_out;
    logic [7:0] pad_out, pad_oe, out_state, in_state, flags;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;  // 50 MHz

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pad_in(pad_in), .alt_en(alt_en),
        .alt_out(alt_out), .pad_out(pad_out), .pad_oe(pad_oe),
        .out_state(out_state), .in_state(in_state), .flags(flags), .irq(irq)
    );

    // Vector: {select, data, expected out_state, expected pad_oe}
    localparam int NVEC = 10;
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd0,  8'hF0, 8'h00, 8'hF0},  // R2 load dir
        {4'd1,  8'h0F, 8'h00, 8'hFF},  // R3 dir set
        {4'd2,  8'h81, 8'h00, 8'h7E},  // R3 dir clear
        {4'd3,  8'h0F, 8'h00, 8'h71},  // R3 dir toggle
        {4'd4,  8'h3C, 8'h3C, 8'h71},  // R2 load out
        {4'd5,  8'h81, 8'hBD, 8'h71},  // R3 out set
        {4'd6,  8'h0C, 8'hB1, 8'h71},  // R3 out clear
        {4'd7,  8'hFF, 8'h4E, 8'h71},  // R3 out toggle
        {4'd14, 8'hFF, 8'h4E, 8'h71},  // R11 unused code
        {4'd15, 8'h00, 8'h4E, 8'h71}   // R11 unused code
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        pad_in = '0; alt_en = '0; alt_out = '0;
        repeat (3) tick();
        // R1 reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 flags", flags, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        tick();

        // R2 R3 R11 register write table
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][27:24], VEC[i][23:16]);
            check("R2/R3/R11 out_state", out_state, VEC[i][15:8]);
            check("R2/R3/R11 pad_oe", pad_oe, VEC[i][7:0]);
            check("R2/R3 pad_out", pad_out, VEC[i][15:8]);
        end
        check("R11 flags", flags, 8'h00);

        // R4 output inversion
        wr(4'd4, 8'hA5);
        wr(4'd8, 8'h0F);
        check("R4 inverted out", pad_out, 8'hAA);
        // R6 input inversion, async default
        check("R6 inverted in", in_state, 8'h0F);
        // R5 alternate override also inverted
        alt_en = 8'h03; alt_out = 8'h03;
        #1;
        check("R5 alt override", pad_out, 8'hA8);
        alt_en = 8'h00;
        #1;
        check("R5 override released", pad_out, 8'hAA);

        // settle: remove inversion, wait for its edge event, clear flags
        wr(4'd8, 8'h00);
        tick();
        wr(4'd11, 8'hFF);
        check("R9 clear all", flags, 8'h00);

        // R7 async input, R8 both-edge flag
        @(negedge clk);
        pad_in = 8'h01;
        #1;
        check("R7 async immediate", in_state, 8'h01);
        tick();
        check("R8 both edge flag", flags, 8'h01);
        check("R10 masked off", {7'd0, irq}, 8'h00);
        wr(4'd10, 8'h01);
        check("R10 irq on", {7'd0, irq}, 8'h01);
        wr(4'd11, 8'h01);
        check("R9 flag cleared", flags, 8'h00);
        check("R10 irq off", {7'd0, irq}, 8'h00);

        // R7 synchronous pin 1
        wr(4'd9, 8'h02);
        @(negedge clk);
        pad_in = 8'h03;
        #1;
        check("R7 sync not yet", in_state, 8'h01);
        tick();
        check("R7 sync after one edge", in_state, 8'h01);
        tick();
        check("R7 sync after two edges", in_state, 8'h03);
        check("R8 sync flag not yet", flags, 8'h00);
        tick();
        check("R8 sync flag", flags, 8'h02);

        // R8 rising (pin2), falling (pin3), low level (pin4)
        wr(4'd12, 8'h14);
        wr(4'd13, 8'h18);
        tick();
        wr(4'd11, 8'hFF);
        check("R9 event beats clear", flags, 8'h10);
        @(negedge clk);
        pad_in = 8'h0F;
        tick();
        check("R8 rise only pin2", flags, 8'h14);
        pad_in = 8'h03;
        tick();
        check("R8 fall pin3", flags, 8'h1C);
        wr(4'd10, 8'h04);
        check("R10 irq pin2", {7'd0, irq}, 8'h01);
        wr(4'd11, 8'h04);
        check("R9 others kept", flags, 8'h18);
        check("R10 irq cleared", {7'd0, irq}, 8'h00);
        wr(4'd14, 8'hFF);
        check("R11 flags kept", flags, 8'h18);
        check("R11 out kept", out_state, 8'hA5);

        // R1 reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        tick();
        check("R1 out after reset", out_state, 8'h00);
        check("R1 oe after reset", pad_oe, 8'h00);
        check("R1 flags after reset", flags, 8'h00);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule